// File: doc/BRIEF.md
# ALU with Carry and Zero Flags

This block is the execute-stage arithmetic and logic unit of a small 32-bit RISC-style core. Each cycle it takes a destination operand, a source operand, a 16-bit immediate and a five-bit operation code. From these it produces a registered result and a register-write strobe. It also keeps two persistent condition flags, carry and zero, which later operations read. Rotates pass through the stored carry. Only arithmetic, rotate and explicit carry operations change the carry flag. The unit also evaluates the jump-if-zero condition, and a taken jump consumes the zero flag.

All outputs are registered, so the result of an operation appears one clock after it is presented. The flags change only on a clock edge where the flag-write enable is high. This lets the surrounding pipeline suppress flag effects for squashed or stalled slots.

Top module: `cfa_alu`

## Requirements
- R1: A synchronous active-high reset clears result_o, wr_en_o, jz_taken_o, carry_o and zero_o.
- R2: Outputs are registered: an operation presented before a clock edge shows on result_o and wr_en_o after that edge. wr_en_o is high exactly for register-writing operations, and result_o is 0 when wr_en_o is low. Operation codes are: 0 NOP, 1 SETC, 2 CLRC, 3 MOV, 4 ADD, 5 SUB, 6 AND, 7 OR, 8 CLR, 9 NOT, 10 INC, 11 DEC, 12 NEG, 13 RLC, 14 RRC, 15 IADD, 16 SHL, 17 SHR, 18 LDM, 19 JZ.
- R3: ADD gives dst+src and SUB gives dst-src. IADD gives dst plus the zero-extended immediate. Each of them writes its carry-out into carry (for SUB this is the carry-out of dst+~src+1).
- R4: MOV gives src and LDM gives the zero-extended immediate. AND and OR give the bitwise combination of dst and src. All four leave carry unchanged.
- R5: Using dst, CLR gives 0, NOT gives ~dst, INC gives dst+1, DEC gives dst-1 and NEG gives -dst. All five leave carry unchanged.
- R6: RLC gives {dst[30:0], carry} and loads dst[31] into carry. RRC gives {carry, dst[31:1]} and loads dst[0] into carry.
- R7: SHL and SHR shift dst by the immediate amount, and SHR fills with zeros. An amount of 32 or more yields 0. Both leave carry unchanged.
- R8: SETC sets carry to 1 and CLRC clears it. Neither writes a register or changes zero.
- R9: Every register-writing operation sets zero to 1 when all 32 result bits are 0, and clears it otherwise.
- R10: jz_taken_o goes high after a JZ that was presented while zero was 1, and a taken JZ clears zero. A JZ with zero at 0 is not taken and changes no flag.
- R11: NOP and the unused codes 20 to 31 write nothing and change no flag.
- R12: With flag_we_i low, carry and zero hold while result_o, wr_en_o and jz_taken_o still respond.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code |
| dst_i | input | 32 | Destination register operand |
| src_i | input | 32 | Source register operand |
| imm_i | input | 16 | Immediate value or shift amount |
| flag_we_i | input | 1 | Allows flag updates at this edge |
| result_o | output | 32 | Registered result |
| wr_en_o | output | 1 | Registered register-write strobe |
| jz_taken_o | output | 1 | Registered jump-if-zero decision |
| carry_o | output | 1 | Carry flag |
| zero_o | output | 1 | Zero flag |

## Verification
Random operation codes, including the unused ones, run with random flag-write enables. Random operands are mixed with the values 0, 1, all-ones and the top bit alone, and the immediates are mixed with small shift counts. This separates carry-producing operations from carry-preserving ones and exposes wrong borrow polarity in subtraction. Long chains of rotates show whether the stored carry, rather than a fresh one, is fed back. Directed sequences pin down the cases that random stimulus rarely reaches: wrap-around to zero on add, equal and unequal subtraction, shift counts of exactly 32 and above, jump-if-zero with each flag state, and a reset after the carry has been set.

// File: rtl/cfa_pkg.sv
package cfa_pkg;
  typedef enum logic [4:0] {
    OP_NOP  = 5'd0,  OP_SETC = 5'd1,  OP_CLRC = 5'd2,  OP_MOV = 5'd3,
    OP_ADD  = 5'd4,  OP_SUB  = 5'd5,  OP_AND  = 5'd6,  OP_OR  = 5'd7,
    OP_CLR  = 5'd8,  OP_NOT  = 5'd9,  OP_INC  = 5'd10, OP_DEC = 5'd11,
    OP_NEG  = 5'd12, OP_RLC  = 5'd13, OP_RRC  = 5'd14, OP_IADD = 5'd15,
    OP_SHL  = 5'd16, OP_SHR  = 5'd17, OP_LDM  = 5'd18, OP_JZ  = 5'd19
  } op_e;

  typedef struct packed {
    logic c_upd;
    logic c_val;
    logic z_upd;
    logic z_val;
  } flag_req_t;
endpackage

// File: rtl/cfa_compute.sv
module cfa_compute
  import cfa_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 16
) (
  input  op_e              op,
  input  logic [W-1:0]     dst,
  input  logic [W-1:0]     src,
  input  logic [IMM_W-1:0] imm,
  input  logic             carry_in,
  output logic [W-1:0]     res,
  output logic             wr,
  output logic             c_upd,
  output logic             c_val
);
  localparam int SHW = $clog2(W);

  logic [W:0]     sum_w;
  logic [W-1:0]   imm_ext;
  logic           shift_big;
  logic [SHW-1:0] shamt;

  assign imm_ext   = W'(imm);
  assign shift_big = (32'(imm) >= 32'(W));
  assign shamt     = imm[SHW-1:0];

  always_comb begin
    res   = '0;
    wr    = 1'b1;
    c_upd = 1'b0;
    c_val = carry_in;
    sum_w = '0;
    unique case (op)
      OP_MOV:  res = src;
      OP_ADD: begin
        sum_w = {1'b0, dst} + {1'b0, src};
        res = sum_w[W-1:0]; c_upd = 1'b1; c_val = sum_w[W];
      end
      OP_SUB: begin
        sum_w = {1'b0, dst} + {1'b0, ~src} + {{W{1'b0}}, 1'b1};
        res = sum_w[W-1:0]; c_upd = 1'b1; c_val = sum_w[W];
      end
      OP_IADD: begin
        sum_w = {1'b0, dst} + {1'b0, imm_ext};
        res = sum_w[W-1:0]; c_upd = 1'b1; c_val = sum_w[W];
      end
      OP_AND:  res = dst & src;
      OP_OR:   res = dst | src;
      OP_CLR:  res = '0;
      OP_NOT:  res = ~dst;
      OP_INC:  res = dst + W'(1);
      OP_DEC:  res = dst - W'(1);
      OP_NEG:  res = W'(0) - dst;
      OP_RLC: begin
        res = {dst[W-2:0], carry_in}; c_upd = 1'b1; c_val = dst[W-1];
      end
      OP_RRC: begin
        res = {carry_in, dst[W-1:1]}; c_upd = 1'b1; c_val = dst[0];
      end
      OP_SHL:  res = shift_big ? '0 : (dst << shamt);
      OP_SHR:  res = shift_big ? '0 : (dst >> shamt);
      OP_LDM:  res = imm_ext;
      OP_SETC: begin wr = 1'b0; c_upd = 1'b1; c_val = 1'b1; end
      OP_CLRC: begin wr = 1'b0; c_upd = 1'b1; c_val = 1'b0; end
      default: wr = 1'b0;
    endcase
  end
endmodule

// File: rtl/cfa_flags.sv
module cfa_flags
  import cfa_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      we,
  input  flag_req_t req,
  output logic      carry_q,
  output logic      zero_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      carry_q <= 1'b0;
      zero_q  <= 1'b0;
    end else if (we) begin
      if (req.c_upd) carry_q <= req.c_val;
      if (req.z_upd) zero_q  <= req.z_val;
    end
  end

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we |=> ($stable(carry_q) && $stable(zero_q))); // R12
endmodule

// File: rtl/cfa_alu.sv
module cfa_alu
  import cfa_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [4:0]       op_i,
  input  logic [W-1:0]     dst_i,
  input  logic [W-1:0]     src_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             flag_we_i,
  output logic [W-1:0]     result_o,
  output logic             wr_en_o,
  output logic             jz_taken_o,
  output logic             carry_o,
  output logic             zero_o
);
  op_e       op;
  logic [W-1:0] res_c;
  logic      wr_c, c_upd_c, c_val_c, jz_hit;
  flag_req_t freq;

  assign op = op_e'(op_i);

  cfa_compute #(.W(W), .IMM_W(IMM_W)) u_compute (
    .op(op), .dst(dst_i), .src(src_i), .imm(imm_i), .carry_in(carry_o),
    .res(res_c), .wr(wr_c), .c_upd(c_upd_c), .c_val(c_val_c)
  );

  assign jz_hit     = (op == OP_JZ) && zero_o;
  assign freq.c_upd = c_upd_c;
  assign freq.c_val = c_val_c;
  assign freq.z_upd = wr_c || jz_hit;
  assign freq.z_val = wr_c ? (res_c == '0) : 1'b0;

  cfa_flags u_flags (
    .clk(clk), .rst(rst), .we(flag_we_i), .req(freq),
    .carry_q(carry_o), .zero_q(zero_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o   <= '0;
      wr_en_o    <= 1'b0;
      jz_taken_o <= 1'b0;
    end else begin
      result_o   <= wr_c ? res_c : '0;
      wr_en_o    <= wr_c;
      jz_taken_o <= jz_hit;
    end
  end

  AST_SETC_ONE: assert property (@(posedge clk) disable iff (rst)
    (flag_we_i && op_i == 5'd1) |=> (carry_o && !wr_en_o)); // R8
  AST_CLRC_ZERO: assert property (@(posedge clk) disable iff (rst)
    (flag_we_i && op_i == 5'd2) |=> (!carry_o && !wr_en_o)); // R8
  AST_LOGIC_KEEPS_CARRY: assert property (@(posedge clk) disable iff (rst)
    (op_i == 5'd6 || op_i == 5'd7) |=> $stable(carry_o)); // R4
  AST_JZ_CONSUMES: assert property (@(posedge clk) disable iff (rst)
    (flag_we_i && op_i == 5'd19 && zero_o) |=> (jz_taken_o && !zero_o)); // R10
  AST_NOP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (op_i == 5'd0 || op_i >= 5'd20) |=>
      (!wr_en_o && $stable(carry_o) && $stable(zero_o))); // R11
  AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && $past(flag_we_i)) |-> (zero_o == (result_o == '0))); // R9
  AST_QUIET_RESULT: assert property (@(posedge clk) disable iff (rst)
    !wr_en_o |-> (result_o == '0)); // R2
endmodule

// File: tb/tb_cfa_alu.sv
module tb_cfa_alu;
  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  op_i;
  logic [31:0] dst_i, src_i;
  logic [15:0] imm_i;
  logic        flag_we_i;
  logic [31:0] result_o;
  logic        wr_en_o, jz_taken_o, carry_o, zero_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic mc, mz;

  always #10 clk = ~clk;

  cfa_alu dut (
    .clk(clk), .rst(rst), .op_i(op_i), .dst_i(dst_i), .src_i(src_i),
    .imm_i(imm_i), .flag_we_i(flag_we_i), .result_o(result_o),
    .wr_en_o(wr_en_o), .jz_taken_o(jz_taken_o), .carry_o(carry_o),
    .zero_o(zero_o)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  function automatic string tag_of(input logic [4:0] op);
    case (op)
      5'd4, 5'd5, 5'd15:              return "R3";
      5'd3, 5'd6, 5'd7, 5'd18:        return "R4";
      5'd8, 5'd9, 5'd10, 5'd11, 5'd12: return "R5";
      5'd13, 5'd14:                   return "R6";
      5'd16, 5'd17:                   return "R7";
      5'd1, 5'd2:                     return "R8";
      5'd19:                          return "R10";
      default:                        return "R11";
    endcase
  endfunction

  task automatic model(input logic [4:0] op, input logic [31:0] s, d,
                       input logic [15:0] im, input logic c,
                       output logic w, output logic [31:0] r,
                       output logic cu, output logic cv);
    logic [63:0] t;
    w = 1'b1; r = 32'h0; cu = 1'b0; cv = c;
    case (op)
      5'd3:  r = s;
      5'd4:  begin t = 64'(d) + 64'(s); r = t[31:0]; cu = 1; cv = t[32]; end
      5'd5:  begin r = d - s; cu = 1; cv = (d >= s); end
      5'd15: begin t = 64'(d) + 64'(im); r = t[31:0]; cu = 1; cv = t[32]; end
      5'd6:  r = d & s;
      5'd7:  r = d | s;
      5'd8:  r = 32'h0;
      5'd9:  r = d ^ 32'hFFFF_FFFF;
      5'd10: r = d + 32'd1;
      5'd11: r = d + 32'hFFFF_FFFF;
      5'd12: r = (d ^ 32'hFFFF_FFFF) + 32'd1;
      5'd13: begin r = (d << 1) | 32'(c); cu = 1; cv = d[31]; end
      5'd14: begin r = (d >> 1) | (32'(c) << 31); cu = 1; cv = d[0]; end
      5'd16: r = (im > 16'd31) ? 32'h0 : d << im;
      5'd17: r = (im > 16'd31) ? 32'h0 : d >> im;
      5'd18: r = {16'h0, im};
      5'd1:  begin w = 0; cu = 1; cv = 1; end
      5'd2:  begin w = 0; cu = 1; cv = 0; end
      default: w = 1'b0;
    endcase
  endtask

  // Called at a negative edge; leaves the bench at the next negative edge.
  task automatic step(input logic [4:0] op, input logic [31:0] s, d,
                      input logic [15:0] im, input logic we);
    logic w, cu, cv, jz;
    logic [31:0] r;
    string tg;
    op_i = op; src_i = s; dst_i = d; imm_i = im; flag_we_i = we;
    model(op, s, d, im, mc, w, r, cu, cv);
    jz = (op == 5'd19) && mz;
    if (we) begin
      if (cu) mc = cv;
      if (w) mz = (r == 32'h0);
      else if (jz) mz = 1'b0;
    end
    @(negedge clk);
    tg = tag_of(op);
    chk("R2", "wr_en", 32'(wr_en_o), 32'(w));
    chk(tg, "result", result_o, w ? r : 32'h0);
    chk(tg, "jz_taken", 32'(jz_taken_o), 32'(jz));
    chk(we ? tg : "R12", "carry", 32'(carry_o), 32'(mc));
    chk(we ? "R9" : "R12", "zero", 32'(zero_o), 32'(mz));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    mc = 1'b0; mz = 1'b0;
    chk("R1", "result", result_o, 32'h0);
    chk("R1", "wr_en", 32'(wr_en_o), 32'h0);
    chk("R1", "jz_taken", 32'(jz_taken_o), 32'h0);
    chk("R1", "carry", 32'(carry_o), 32'h0);
    chk("R1", "zero", 32'(zero_o), 32'h0);
    rst = 1'b0;
  endtask

  function automatic logic [31:0] pick32();
    case ($urandom_range(0, 7))
      0: return 32'h0;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'h1;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed_init;
    seed_init = $urandom(32'd20240611);
    rst = 1'b1; op_i = '0; src_i = '0; dst_i = '0; imm_i = '0; flag_we_i = 1'b0;
    @(negedge clk);
    do_reset();
    // R8 set carry, then R6 rotates through it
    step(5'd1, 0, 0, 0, 1);
    step(5'd13, 0, 32'h8000_0001, 0, 1);
    step(5'd14, 0, 32'h0000_0002, 0, 1);
    // R3 add wrap and subtraction borrow, R9 zero
    step(5'd4, 32'h1, 32'hFFFF_FFFF, 0, 1);
    step(5'd19, 0, 0, 0, 1);          // R10 taken, clears zero
    step(5'd19, 0, 0, 0, 1);          // R10 not taken
    step(5'd5, 32'd5, 32'd5, 0, 1);
    step(5'd19, 0, 0, 0, 0);          // R10 taken but flags held (R12)
    step(5'd5, 32'd5, 32'd3, 0, 1);
    step(5'd15, 0, 32'hFFFF_FFF0, 16'h0010, 1);
    // R7 shift limits
    step(5'd16, 0, 32'hFFFF_FFFF, 16'd32, 1);
    step(5'd17, 0, 32'hFFFF_FFFF, 16'd40, 1);
    step(5'd17, 0, 32'h8000_0000, 16'd31, 1);
    step(5'd16, 0, 32'h1, 16'd31, 1);
    // R12 flags held, R11 unused code
    step(5'd4, 32'h1, 32'hFFFF_FFFF, 0, 0);
    step(5'd25, 32'h0, 32'h0, 0, 1);
    step(5'd0, 0, 0, 0, 1);
    // R1 reset after carry set
    step(5'd1, 0, 0, 0, 1);
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] im;
      im = ($urandom_range(0, 1) == 0) ? 16'($urandom_range(0, 40)) : 16'($urandom);
      step(5'($urandom_range(0, 31)), pick32(), pick32(), im,
           ($urandom_range(0, 5) != 0));
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule